// File: doc/BRIEF.md
# Vector Pair Even/Odd Permute Unit

This unit forms a destination vector group of the same size as its two source groups by taking neighbouring elements from both sources in turn. In the even variant, each even destination slot keeps the second source's element at the same index, and each odd slot takes the first source's element one position lower. In the odd variant, each odd slot keeps the first source's element at the same index, and each even slot takes the second source's element one position higher. That higher element reads as zero once its index reaches the maximum element count of the group. Masking and the active length decide which slots are written. Every other slot keeps the old destination value.

A pulse on `start_i` launches one operation on the operands presented in that cycle. One cycle later, `done_o` pulses together with the registered result. The operands come in as flat byte-ordered groups: element i of width SEW bytes starts at byte i*SEW. The unit also screens the operation for illegal register choices, illegal encodings and illegal configurations. When it finds one, it raises `illegal_o` with `done_o` and does not update the result.

Top module: `vpair_unit`

## Requirements
- R1: With `fn3_i`=3'b000 (even variant, an instruction with funct6 001111 and major opcode 1010111), a written element i takes source-2 element i when i is even, and source-1 element i-1 when i is odd.
- R2: With `fn3_i`=3'b010 (odd variant, same funct6 and opcode), a written odd element i takes source-1 element i, and a written even element i takes source-2 element i+1, or zero when i+1 is not below `vlmax_i`.
- R3: With `vm_i`=0, element i is written only if bit i of `mask_i` is 1; with `vm_i`=1 the mask is ignored and every element below the length is written.
- R4: Elements with index not below `vl_i` keep their value from `vd_old_i`.
- R5: The operation is illegal when `vd_idx_i` equals `vs1_idx_i` or `vs2_idx_i`.
- R6: The operation is illegal when `vm_i`=1 and `vd_idx_i`=0; with `vm_i`=0 a destination index of 0 is allowed.
- R7: Any `fn3_i` other than 3'b000 and 3'b010 is illegal.
- R8: The operation is illegal unless `vlmax_i` equals 2^(LMUL exponent + log2(VLEN) - log2(SEW)). Here `lmul_i` is a signed exponent, `sew_i` codes 0..3 mean SEW of 8, 16, 32 and 64 bits, the exponent must not be negative, and the LMUL exponent must not exceed MAX_LMUL_LOG.
- R9: `done_o` is high exactly in the cycle after a cycle with `start_i` high. `illegal_o` pulses with `done_o` for an illegal operation, and the result output stays unchanged in that case.
- R10: After reset, `vd_o` is all zeros and `done_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation on the present operands |
| fn3_i | input | 3 | Variant code: 000 even, 010 odd |
| vm_i | input | 1 | 1 = unmasked, 0 = use `mask_i` |
| vd_idx_i | input | 5 | Destination register index |
| vs1_idx_i | input | 5 | Source-1 register index |
| vs2_idx_i | input | 5 | Source-2 register index |
| sew_i | input | 2 | Element width code (8 << code bits) |
| lmul_i | input | 3 | Signed group-size exponent |
| vlmax_i | input | CW | Maximum element count of the group |
| vl_i | input | CW | Active element count |
| mask_i | input | GB | One mask bit per element |
| vs1_i | input | GB*8 | Source-1 group |
| vs2_i | input | GB*8 | Source-2 group |
| vd_old_i | input | GB*8 | Previous destination group |
| vd_o | output | GB*8 | Registered destination group |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Operation was rejected |

## Verification
The hardest case to reach is the zero fill of the odd variant. With power-of-two group sizes and a length no larger than VLMAX, an active even slot reaches i+1 = VLMAX only when VLMAX is 1. The sweep therefore covers every legal SEW and LMUL pairing, including 64-bit elements at unit LMUL, where VLMAX is 1. It also drives lengths two beyond VLMAX, so that even slots past VLMAX are written and must read zero. Each illegal case first follows a legal operation with known data, so that an unchanged result can be seen at the output.

// File: rtl/vpair_pkg.sv
package vpair_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        FN3_EVEN = 3'b000,
        FN3_ODD  = 3'b010
    } pair_fn_e;

endpackage

// File: rtl/vpair_legal.sv
module vpair_legal
    import vpair_pkg::*;
#(
    parameter int VLEN         = 64,
    parameter int MAX_LMUL_LOG = 3,
    parameter int CW           = 7
) (
    input  logic [2:0]    fn3_i,
    input  logic          vm_i,
    input  logic [4:0]    vd_idx_i,
    input  logic [4:0]    vs1_idx_i,
    input  logic [4:0]    vs2_idx_i,
    input  logic [1:0]    sew_i,
    input  logic [2:0]    lmul_i,
    input  logic [CW-1:0] vlmax_i,
    output logic          illegal_o
);
    localparam int VLEN_LOG = $clog2(VLEN);

    logic overlap;
    logic unmasked_v0;
    logic bad_fn;
    logic bad_cfg;
    int   lmul_s;
    int   vlmax_exp;

    always_comb begin
        overlap     = (vd_idx_i == vs1_idx_i) || (vd_idx_i == vs2_idx_i);
        unmasked_v0 = vm_i && (vd_idx_i == 5'd0);
        bad_fn      = (fn3_i != FN3_EVEN) && (fn3_i != FN3_ODD);
        lmul_s      = int'($signed(lmul_i));
        vlmax_exp   = lmul_s + VLEN_LOG - $clog2(BYTE_W) - int'(sew_i);
        if ((lmul_s > MAX_LMUL_LOG) || (vlmax_exp < 0)) begin
            bad_cfg = 1'b1;
        end else begin
            bad_cfg = (int'(vlmax_i) != (1 << vlmax_exp));
        end
        illegal_o = overlap || unmasked_v0 || bad_fn || bad_cfg;
    end

endmodule

// File: rtl/vpair_lane.sv
module vpair_lane
    import vpair_pkg::*;
#(
    parameter int LANE = 0,
    parameter int GB   = 64,
    parameter int CW   = 7
) (
    input  logic                     odd_var_i,
    input  logic                     vm_i,
    input  logic [1:0]               sew_i,
    input  logic [CW-1:0]            vl_i,
    input  logic [CW-1:0]            vlmax_i,
    input  logic [GB-1:0]            mask_i,
    input  logic [BYTE_W-1:0]        own_vs1_i,
    input  logic [BYTE_W-1:0]        own_vs2_i,
    input  logic [BYTE_W-1:0]        own_old_i,
    input  logic [3:0][BYTE_W-1:0]   dn_vs1_i,
    input  logic [3:0][BYTE_W-1:0]   up_vs2_i,
    output logic [BYTE_W-1:0]        byte_o
);
    localparam int IW = CW - 1;
    localparam logic [IW-1:0] LANE_V = IW'(LANE);

    logic [3:0]        up_ok;
    logic [IW-1:0]     elem;
    logic [CW-1:0]     elem_w;
    logic              is_odd;
    logic              wr_en;
    logic [BYTE_W-1:0] cand;

    for (genvar s = 0; s < 4; s++) begin : g_upok
        assign up_ok[s] = (LANE + (1 << s)) < GB;
    end

    always_comb begin
        elem   = LANE_V >> sew_i;
        elem_w = {1'b0, elem};
        is_odd = elem[0];
        if (!odd_var_i) begin
            cand = is_odd ? dn_vs1_i[sew_i] : own_vs2_i;
        end else if (is_odd) begin
            cand = own_vs1_i;
        end else if (((elem_w + CW'(1)) < vlmax_i) && up_ok[sew_i]) begin
            cand = up_vs2_i[sew_i];
        end else begin
            cand = '0;
        end
        wr_en  = (elem_w < vl_i) && (vm_i || mask_i[elem]);
        byte_o = wr_en ? cand : own_old_i;
    end

endmodule

// File: rtl/vpair_unit.sv
module vpair_unit
    import vpair_pkg::*;
#(
    parameter int VLEN         = 64,
    parameter int MAX_LMUL_LOG = 3,
    localparam int GB          = (VLEN / BYTE_W) << MAX_LMUL_LOG,
    localparam int GBITS       = GB * BYTE_W,
    localparam int CW          = $clog2(GB) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       fn3_i,
    input  logic             vm_i,
    input  logic [4:0]       vd_idx_i,
    input  logic [4:0]       vs1_idx_i,
    input  logic [4:0]       vs2_idx_i,
    input  logic [1:0]       sew_i,
    input  logic [2:0]       lmul_i,
    input  logic [CW-1:0]    vlmax_i,
    input  logic [CW-1:0]    vl_i,
    input  logic [GB-1:0]    mask_i,
    input  logic [GBITS-1:0] vs1_i,
    input  logic [GBITS-1:0] vs2_i,
    input  logic [GBITS-1:0] vd_old_i,
    output logic [GBITS-1:0] vd_o,
    output logic             done_o,
    output logic             illegal_o
);
    typedef struct packed {
        logic [GBITS-1:0] result;
        logic             done;
        logic             illegal;
    } unit_state_t;

    unit_state_t      st_d, st_q;
    logic             illegal_d;
    logic             odd_var;
    logic [GBITS-1:0] lane_res;

    assign odd_var = (fn3_i == FN3_ODD);

    vpair_legal #(
        .VLEN(VLEN), .MAX_LMUL_LOG(MAX_LMUL_LOG), .CW(CW)
    ) u_legal (
        .fn3_i(fn3_i), .vm_i(vm_i), .vd_idx_i(vd_idx_i),
        .vs1_idx_i(vs1_idx_i), .vs2_idx_i(vs2_idx_i), .sew_i(sew_i),
        .lmul_i(lmul_i), .vlmax_i(vlmax_i), .illegal_o(illegal_d)
    );

    for (genvar g = 0; g < GB; g++) begin : g_lane
        logic [3:0][BYTE_W-1:0] dn_b;
        logic [3:0][BYTE_W-1:0] up_b;
        for (genvar s = 0; s < 4; s++) begin : g_sew
            localparam int SB  = 1 << s;
            localparam int DNI = (g >= SB) ? g - SB : 0;
            localparam int UPI = (g + SB < GB) ? g + SB : g;
            assign dn_b[s] = vs1_i[BYTE_W*DNI +: BYTE_W];
            assign up_b[s] = vs2_i[BYTE_W*UPI +: BYTE_W];
        end
        vpair_lane #(.LANE(g), .GB(GB), .CW(CW)) u_lane (
            .odd_var_i(odd_var), .vm_i(vm_i), .sew_i(sew_i),
            .vl_i(vl_i), .vlmax_i(vlmax_i), .mask_i(mask_i),
            .own_vs1_i(vs1_i[BYTE_W*g +: BYTE_W]),
            .own_vs2_i(vs2_i[BYTE_W*g +: BYTE_W]),
            .own_old_i(vd_old_i[BYTE_W*g +: BYTE_W]),
            .dn_vs1_i(dn_b), .up_vs2_i(up_b),
            .byte_o(lane_res[BYTE_W*g +: BYTE_W])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.done    = start_i;
        st_d.illegal = start_i && illegal_d;
        if (start_i && !illegal_d) begin
            st_d.result = lane_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vd_o      = st_q.result;
    assign done_o    = st_q.done;
    assign illegal_o = st_q.illegal;

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R9
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o); // R9
    AST_ILLEGAL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($stable(vd_o) && done_o)); // R9
    AST_OVERLAP_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ((vd_idx_i == vs1_idx_i) || (vd_idx_i == vs2_idx_i))) |=> illegal_o); // R5
    AST_UNMASKED_V0_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && vm_i && (vd_idx_i == 5'd0)) |=> illegal_o); // R6
    AST_BAD_FN3_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (fn3_i != 3'b000) && (fn3_i != 3'b010)) |=> illegal_o); // R7

endmodule

// File: tb/sim_vpair_unit.sv
module sim_vpair_unit;
    localparam int CLK_PERIOD = 10;
    localparam int GB    = 64;
    localparam int GBITS = GB * 8;
    localparam int CW    = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [2:0]       fn3_i = '0;
    logic             vm_i = 1'b0;
    logic [4:0]       vd_idx_i = '0, vs1_idx_i = '0, vs2_idx_i = '0;
    logic [1:0]       sew_i = '0;
    logic [2:0]       lmul_i = '0;
    logic [CW-1:0]    vlmax_i = '0, vl_i = '0;
    logic [GB-1:0]    mask_i = '0;
    logic [GBITS-1:0] vs1_i = '0, vs2_i = '0, vd_old_i = '0;
    logic [GBITS-1:0] vd_o;
    logic             done_o, illegal_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpair_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fn3_i(fn3_i), .vm_i(vm_i),
        .vd_idx_i(vd_idx_i), .vs1_idx_i(vs1_idx_i), .vs2_idx_i(vs2_idx_i),
        .sew_i(sew_i), .lmul_i(lmul_i), .vlmax_i(vlmax_i), .vl_i(vl_i),
        .mask_i(mask_i), .vs1_i(vs1_i), .vs2_i(vs2_i), .vd_old_i(vd_old_i),
        .vd_o(vd_o), .done_o(done_o), .illegal_o(illegal_o)
    );

    task automatic check(input bit ok, input string req, input logic [GBITS-1:0] act,
                         input logic [GBITS-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [GBITS-1:0] rand_group();
        logic [GBITS-1:0] r;
        for (int w = 0; w < GBITS/32; w++) r[32*w +: 32] = $urandom();
        return r;
    endfunction

    function automatic logic [63:0] get_el(logic [GBITS-1:0] v, int e, int eb);
        logic [63:0] x;
        x = 64'(v >> (e*eb));
        if (eb < 64) x = x & ((64'd1 << eb) - 64'd1);
        return x;
    endfunction

    function automatic logic [GBITS-1:0] ref_pair(bit odd, int sew, int vlmax, int vl, bit vm,
            logic [GB-1:0] m, logic [GBITS-1:0] a1, logic [GBITS-1:0] a2, logic [GBITS-1:0] old);
        logic [GBITS-1:0] r;
        logic [63:0] v;
        int eb, ne;
        r  = old;
        eb = 8 << sew;
        ne = GB >> sew;
        for (int e = 0; e < ne; e++) begin
            if (e < vl && (vm || m[e])) begin
                if (!odd) v = (e % 2 == 0) ? get_el(a2, e, eb) : get_el(a1, e-1, eb);
                else if (e % 2 == 1) v = get_el(a1, e, eb);
                else v = (e + 1 < vlmax) ? get_el(a2, e+1, eb) : 64'd0;
                for (int b = 0; b < eb; b++) r[e*eb + b] = v[b];
            end
        end
        return r;
    endfunction

    task automatic launch();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic setup(input logic [2:0] f, input int sew, input int l, input int vmx,
                         input int vl, input bit vm, input int vd, input int s1, input int s2);
        fn3_i = f; sew_i = 2'(sew); lmul_i = 3'(l); vlmax_i = CW'(vmx); vl_i = CW'(vl);
        vm_i = vm; vd_idx_i = 5'(vd); vs1_idx_i = 5'(s1); vs2_idx_i = 5'(s2);
        mask_i = {$urandom(), $urandom()};
        vs1_i = rand_group(); vs2_i = rand_group(); vd_old_i = rand_group();
    endtask

    task automatic illegal_case(input string req, input logic [2:0] f, input int sew,
            input int l, input int vmx, input bit vm, input int vd, input int s1, input int s2);
        logic [GBITS-1:0] held;
        setup(3'b000, 0, 0, 8, 8, 1'b1, 8, 16, 24);
        launch();
        held = vd_o;
        setup(f, sew, l, vmx, vmx, vm, vd, s1, s2);
        launch();
        check(illegal_o === 1'b1 && done_o === 1'b1, req, {510'd0, done_o, illegal_o}, 512'd3);
        check(vd_o === held, {req, " R9 hold"}, vd_o, held);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual no completion expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [GBITS-1:0] exp;
        repeat (3) @(negedge clk);
        check(vd_o === '0 && done_o === 1'b0 && illegal_o === 1'b0, "R10 reset",
              {vd_o[GBITS-1:2] | GBITS'(0), done_o, illegal_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o === 1'b0, "R9 idle", {511'd0, done_o}, '0);

        for (int odd = 0; odd < 2; odd++)
        for (int sew = 0; sew < 4; sew++)
        for (int l = sew - 3; l <= 3; l++)
        for (int k = 0; k < 5; k++)
        for (int vm = 0; vm < 2; vm++) begin
            int vmx, vl;
            vmx = 1 << (l + 3 - sew);
            case (k)
                0: vl = 0;
                1: vl = 1;
                2: vl = vmx / 2;
                3: vl = vmx;
                default: vl = vmx + 2;
            endcase
            setup(odd ? 3'b010 : 3'b000, sew, l, vmx, vl, vm[0], 8, 16, 24);
            exp = ref_pair(odd[0], sew, vmx, vl, vm[0], mask_i, vs1_i, vs2_i, vd_old_i);
            launch();
            check(done_o === 1'b1 && illegal_o === 1'b0, "R9 R8 legal done",
                  {510'd0, done_o, illegal_o}, 512'd2);
            check(vd_o === exp, odd ? "R2 R3 R4 odd" : "R1 R3 R4 even", vd_o, exp);
            @(negedge clk);
            check(done_o === 1'b0, "R9 single pulse", {511'd0, done_o}, '0);
        end

        // masked with destination 0 is legal
        setup(3'b000, 1, 1, 8, 8, 1'b0, 0, 4, 5);
        exp = ref_pair(1'b0, 1, 8, 8, 1'b0, mask_i, vs1_i, vs2_i, vd_old_i);
        launch();
        check(illegal_o === 1'b0 && vd_o === exp, "R6 masked v0 legal", vd_o, exp);

        illegal_case("R5 vd==vs1", 3'b000, 0, 0, 8, 1'b0, 8, 8, 24);
        illegal_case("R5 vd==vs2", 3'b010, 0, 0, 8, 1'b0, 8, 16, 8);
        illegal_case("R6 unmasked v0", 3'b000, 0, 0, 8, 1'b1, 0, 16, 24);
        illegal_case("R7 fn3 001", 3'b001, 0, 0, 8, 1'b0, 8, 16, 24);
        illegal_case("R7 fn3 110", 3'b110, 0, 0, 8, 1'b0, 8, 16, 24);
        illegal_case("R8 vlmax mismatch", 3'b000, 0, 0, 16, 1'b0, 8, 16, 24);
        illegal_case("R8 negative exponent", 3'b010, 3, -1, 1, 1'b0, 8, 16, 24);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule